// File: doc/BRIEF.md
# Scan Code to ASCII Translator

This block turns a stream of keyboard scan code set 2 bytes into characters. Each incoming byte arrives with a one-cycle valid strobe. In translation mode the block follows release and extended prefixes, both shift keys and a caps lock toggle, and emits the ASCII code of each letter, digit, space or enter key that is pressed. In raw mode every incoming byte is copied to the output unchanged. A single output byte with a valid strobe feeds both the parallel and the serial paths downstream.

A repeat-enable input decides how auto-repeat from a held key is handled. When it is high, every repeated press code produces a character. When it is low, a press code that matches the key still held produces nothing until that key is released. Modifier and lock state is tracked in both modes, so switching modes does not lose the keyboard's state.

Top module: `scan_ascii_xlat`

## Requirements
- R1: After reset `outValid` is 0, both shift keys count as released and caps lock is off, so the first letter comes out in lowercase.
- R2: With `rawMode`=1, every input byte, prefixes included, appears unchanged on `outByte` with `outValid`=1 one clock after it is sampled.
- R3: With `rawMode`=0, a press of a letter key gives its lowercase ASCII code (for example 0x1C gives 0x61 'a') one clock after sampling.
- R4: Digit keys give 0x30..0x39 (0x45 gives '0', 0x16 gives '1'), 0x29 gives 0x20 and 0x5A gives 0x0D. Shift and lock do not change these codes.
- R5: Press codes 0x12 and 0x59 mark a shift key as held, and their release clears it. While either key is held, letters come out in uppercase (the ASCII code minus 0x20).
- R6: Each fresh press of 0x58 toggles caps lock. A repeated 0x58 press with no release in between does not toggle it. A letter is uppercase when shift XOR lock is 1.
- R7: Byte 0xF0 produces no output and marks the next code as a release. A release produces no output.
- R8: Byte 0xE0 produces no output and marks the next code as extended. Extended codes, and extended releases that follow 0xE0 0xF0, produce no output and do not change the shift state.
- R9: Codes with no character assigned, including the modifier keys themselves, produce no output in translation mode.
- R10: With `repeatEn`=1, a repeated press of the held key produces its character every time. With `repeatEn`=0, a press equal to the last pressed key, with no release of it in between, is suppressed.
- R11: `outValid` is high for exactly one clock per accepted byte and is never high unless `inValid` was high on the clock before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte strobe |
| inByte | input | 8 | Scan code set 2 byte |
| rawMode | input | 1 | 1 = copy bytes through unchanged, 0 = translate to ASCII |
| repeatEn | input | 1 | 1 = held keys repeat, 0 = one character per press |
| outValid | output | 1 | Output byte strobe, one clock wide |
| outByte | output | 8 | ASCII character or raw byte |

## Verification
Every result that exists appears in the cycle after its input byte is sampled, because a single output register sits between `inByte` and `outByte`. The bench drives each byte on a falling edge and holds it for one full clock. It then samples `outValid` and `outByte` on the next falling edge, which is exactly one register stage later. Suppressed, prefix and release bytes are checked at that same sample point for `outValid`=0. Because no byte may leak out late, back-to-back bytes are sent with no idle cycles between them.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] BREAK_PFX = 8'hF0;
  localparam logic [BYTE_W-1:0] EXT_PFX   = 8'hE0;
  localparam logic [BYTE_W-1:0] SHIFT_L   = 8'h12;
  localparam logic [BYTE_W-1:0] SHIFT_R   = 8'h59;
  localparam logic [BYTE_W-1:0] CAPS_KEY  = 8'h58;
  localparam logic [BYTE_W-1:0] CASE_GAP  = 8'h20;

  typedef struct packed {
    logic emit;
    logic raw;
    logic upper;
  } ctrlStrobes_t;

  typedef struct packed {
    logic              hit;
    logic              letter;
    logic [BYTE_W-1:0] ascii;
  } lookup_t;
endpackage

// File: rtl/sx_ctrl.sv
module sx_ctrl
  import sx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              rawMode,
  input  logic              repeatEn,
  output ctrlStrobes_t      strobes
);
  logic brkPend, extPend, shiftL, shiftR, lockOn;
  logic [BYTE_W-1:0] heldKey;

  logic isBrk, isExt, isPrefix, plainMake, repeatHit;

  always_comb begin
    isBrk     = (inByte == BREAK_PFX);
    isExt     = (inByte == EXT_PFX);
    isPrefix  = isBrk | isExt;
    plainMake = !isPrefix && !brkPend && !extPend;
    repeatHit = plainMake && (heldKey != '0) && (inByte == heldKey);
    strobes.raw   = rawMode;
    strobes.upper = (shiftL | shiftR) ^ lockOn;
    strobes.emit  = inValid && (rawMode || (plainMake && (repeatEn || !repeatHit)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkPend <= 1'b0;
      extPend <= 1'b0;
      shiftL  <= 1'b0;
      shiftR  <= 1'b0;
      lockOn  <= 1'b0;
      heldKey <= '0;
    end else if (inValid) begin
      if (isBrk) begin
        brkPend <= 1'b1;
      end else if (isExt) begin
        extPend <= 1'b1;
      end else begin
        brkPend <= 1'b0;
        extPend <= 1'b0;
        if (!extPend) begin
          if (brkPend) begin
            if (inByte == SHIFT_L) shiftL <= 1'b0;
            if (inByte == SHIFT_R) shiftR <= 1'b0;
            if (inByte == heldKey) heldKey <= '0;
          end else begin
            if (inByte == SHIFT_L) shiftL <= 1'b1;
            if (inByte == SHIFT_R) shiftR <= 1'b1;
            if (inByte == CAPS_KEY && !repeatHit) lockOn <= !lockOn;
            heldKey <= inByte;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sx_datapath.sv
module sx_datapath
  import sx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  ctrlStrobes_t      strobes,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte
);
  function automatic lookup_t mapCode(input logic [BYTE_W-1:0] code);
    lookup_t r;
    r.hit = 1'b1;
    r.letter = 1'b1;
    r.ascii = '0;
    case (code)
      8'h1C: r.ascii = 8'h61; 8'h32: r.ascii = 8'h62; 8'h21: r.ascii = 8'h63;
      8'h23: r.ascii = 8'h64; 8'h24: r.ascii = 8'h65; 8'h2B: r.ascii = 8'h66;
      8'h34: r.ascii = 8'h67; 8'h33: r.ascii = 8'h68; 8'h43: r.ascii = 8'h69;
      8'h3B: r.ascii = 8'h6A; 8'h42: r.ascii = 8'h6B; 8'h4B: r.ascii = 8'h6C;
      8'h3A: r.ascii = 8'h6D; 8'h31: r.ascii = 8'h6E; 8'h44: r.ascii = 8'h6F;
      8'h4D: r.ascii = 8'h70; 8'h15: r.ascii = 8'h71; 8'h2D: r.ascii = 8'h72;
      8'h1B: r.ascii = 8'h73; 8'h2C: r.ascii = 8'h74; 8'h3C: r.ascii = 8'h75;
      8'h2A: r.ascii = 8'h76; 8'h1D: r.ascii = 8'h77; 8'h22: r.ascii = 8'h78;
      8'h35: r.ascii = 8'h79; 8'h1A: r.ascii = 8'h7A;
      default: begin
        r.letter = 1'b0;
        case (code)
          8'h45: r.ascii = 8'h30; 8'h16: r.ascii = 8'h31; 8'h1E: r.ascii = 8'h32;
          8'h26: r.ascii = 8'h33; 8'h25: r.ascii = 8'h34; 8'h2E: r.ascii = 8'h35;
          8'h36: r.ascii = 8'h36; 8'h3D: r.ascii = 8'h37; 8'h3E: r.ascii = 8'h38;
          8'h46: r.ascii = 8'h39; 8'h29: r.ascii = 8'h20; 8'h5A: r.ascii = 8'h0D;
          default: r.hit = 1'b0;
        endcase
      end
    endcase
    return r;
  endfunction

  lookup_t hitInfo;
  logic [BYTE_W-1:0] xlated;

  always_comb begin
    hitInfo = mapCode(inByte);
    xlated  = (hitInfo.letter && strobes.upper) ? hitInfo.ascii - CASE_GAP : hitInfo.ascii;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      outValid <= strobes.emit && (strobes.raw || hitInfo.hit);
      if (strobes.emit) outByte <= strobes.raw ? inByte : xlated;
    end
  end
endmodule

// File: rtl/scan_ascii_xlat.sv
module scan_ascii_xlat
  import sx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              rawMode,
  input  logic              repeatEn,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte
);
  ctrlStrobes_t strobes;

  sx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .rawMode(rawMode), .repeatEn(repeatEn), .strobes(strobes)
  );

  sx_datapath i_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .strobes(strobes),
    .outValid(outValid), .outByte(outByte)
  );
endmodule

// File: rtl/sx_checker.sv
module sx_checker
  import sx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [BYTE_W-1:0] inByte,
  input logic              rawMode,
  input logic              outValid,
  input logic [BYTE_W-1:0] outByte
);
  function automatic logic legalChar(input logic [BYTE_W-1:0] c);
    return (c == 8'h0D) || (c == 8'h20) || (c >= 8'h30 && c <= 8'h39) ||
           (c >= 8'h41 && c <= 8'h5A) || (c >= 8'h61 && c <= 8'h7A);
  endfunction

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R11
  AST_RAW_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    inValid && rawMode |=> outValid && outByte == $past(inByte)); // R2
  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !rawMode && (inByte == BREAK_PFX || inByte == EXT_PFX) |=> !outValid); // R7
  AST_CHAR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(rawMode) |-> legalChar(outByte)); // R4
  AST_MODIFIER_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !rawMode && (inByte == SHIFT_L || inByte == CAPS_KEY) |=> !outValid); // R9
endmodule

bind scan_ascii_xlat sx_checker i_sx_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
  .rawMode(rawMode), .outValid(outValid), .outByte(outByte)
);

// File: tb/test_scan_ascii_xlat.sv
module test_scan_ascii_xlat;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic rawMode = 1'b0;
  logic repeatEn = 1'b1;
  logic outValid;
  logic [7:0] outByte;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  scan_ascii_xlat i_scan_ascii_xlat (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .rawMode(rawMode), .repeatEn(repeatEn), .outValid(outValid), .outByte(outByte)
  );

  task automatic check(input string req, input logic expV, input logic [7:0] expB);
    checks++;
    if (outValid !== expV || (expV && outByte !== expB)) begin
      failures++;
      $display("FAIL %s: valid=%0b byte=%02h expected valid=%0b byte=%02h",
               req, outValid, outByte, expV, expB);
    end
  endtask

  // send one byte; outputs are due one clock after sampling
  task automatic send(input logic [7:0] b, input logic expV, input logic [7:0] expB, input string req);
    inValid = 1'b1;
    inByte = b;
    @(negedge clk);
    inValid = 1'b0;
    check(req, expV, expB);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset", 1'b0, 8'h00);
    send(8'h1C, 1'b1, 8'h61, "R1 first letter lowercase");
  endtask

  task automatic testRaw();
    rawMode = 1'b1;
    send(8'h1C, 1'b1, 8'h1C, "R2 raw make");
    send(8'hF0, 1'b1, 8'hF0, "R2 raw break prefix");
    send(8'h1C, 1'b1, 8'h1C, "R2 raw release");
    send(8'hE0, 1'b1, 8'hE0, "R2 raw ext prefix");
    send(8'h75, 1'b1, 8'h75, "R2 raw ext code");
    rawMode = 1'b0;
  endtask

  task automatic testBasic();
    send(8'h32, 1'b1, 8'h62, "R3 letter b");
    send(8'hF0, 1'b0, 8'h00, "R7 break prefix silent");
    send(8'h32, 1'b0, 8'h00, "R7 release silent");
    send(8'h45, 1'b1, 8'h30, "R4 digit 0");
    send(8'h16, 1'b1, 8'h31, "R4 digit 1");
    send(8'h29, 1'b1, 8'h20, "R4 space");
    send(8'h5A, 1'b1, 8'h0D, "R4 enter");
  endtask

  task automatic testShift();
    send(8'h12, 1'b0, 8'h00, "R9 left shift silent");
    send(8'h1C, 1'b1, 8'h41, "R5 shifted A");
    send(8'h16, 1'b1, 8'h31, "R4 digit ignores shift");
    send(8'hF0, 1'b0, 8'h00, "R7 prefix");
    send(8'h12, 1'b0, 8'h00, "R5 shift release");
    send(8'h1C, 1'b1, 8'h61, "R5 after release lowercase");
    send(8'h59, 1'b0, 8'h00, "R9 right shift silent");
    send(8'h21, 1'b1, 8'h43, "R5 right shift C");
    send(8'hF0, 1'b0, 8'h00, "R7 prefix");
    send(8'h59, 1'b0, 8'h00, "R5 right release");
  endtask

  task automatic testLock();
    send(8'h58, 1'b0, 8'h00, "R6 lock press silent");
    send(8'h58, 1'b0, 8'h00, "R6 lock repeat silent");
    send(8'hF0, 1'b0, 8'h00, "R7 prefix");
    send(8'h58, 1'b0, 8'h00, "R6 lock release");
    send(8'h1C, 1'b1, 8'h41, "R6 lock on uppercase (repeat did not toggle)");
    send(8'h12, 1'b0, 8'h00, "R6 shift");
    send(8'h1C, 1'b1, 8'h61, "R6 shift xor lock lowercase");
    send(8'hF0, 1'b0, 8'h00, "R7 prefix");
    send(8'h12, 1'b0, 8'h00, "R6 shift release");
    send(8'h58, 1'b0, 8'h00, "R6 lock toggle off");
    send(8'hF0, 1'b0, 8'h00, "R7 prefix");
    send(8'h58, 1'b0, 8'h00, "R6 lock release");
    send(8'h1C, 1'b1, 8'h61, "R6 lock off lowercase");
  endtask

  task automatic testExtended();
    send(8'hE0, 1'b0, 8'h00, "R8 ext prefix silent");
    send(8'h1C, 1'b0, 8'h00, "R8 ext code silent");
    send(8'hE0, 1'b0, 8'h00, "R8 ext prefix");
    send(8'h12, 1'b0, 8'h00, "R8 ext shift silent");
    send(8'h21, 1'b1, 8'h63, "R8 ext shift no effect");
    send(8'hE0, 1'b0, 8'h00, "R8 ext prefix");
    send(8'hF0, 1'b0, 8'h00, "R8 ext break prefix");
    send(8'h12, 1'b0, 8'h00, "R8 ext release silent");
    send(8'h05, 1'b0, 8'h00, "R9 unmapped code");
    send(8'h76, 1'b0, 8'h00, "R9 unmapped code 2");
  endtask

  task automatic testRepeat();
    repeatEn = 1'b1;
    send(8'h24, 1'b1, 8'h65, "R10 press e");
    send(8'h24, 1'b1, 8'h65, "R10 repeat allowed");
    repeatEn = 1'b0;
    send(8'h24, 1'b0, 8'h00, "R10 repeat suppressed");
    send(8'h24, 1'b0, 8'h00, "R10 repeat suppressed again");
    send(8'hF0, 1'b0, 8'h00, "R7 prefix");
    send(8'h24, 1'b0, 8'h00, "R10 release");
    send(8'h24, 1'b1, 8'h65, "R10 fresh press after release");
    send(8'h23, 1'b1, 8'h64, "R10 other key");
    send(8'h24, 1'b1, 8'h65, "R10 earlier key after other key");
    @(negedge clk);
    check("R11 no output when idle", 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRaw();
    testBasic();
    testShift();
    testLock();
    testExtended();
    testRepeat();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule